// File: doc/BRIEF.md
# Bit-Sliced Multifunction ALU

This block is an integer arithmetic and logic unit made from a chain of identical one-bit slices. Each slice forms the bitwise AND, OR and NOR of its two operand bits and a full-adder sum, and a 4-to-1 multiplexer inside the slice picks one of the four as that slice's result bit. Carries ripple from each slice into the next one up. When subtraction is requested, every bit of the second operand is inverted and the carry into the lowest slice is forced to 1. The adder therefore computes `a + (~b) + 1`, which is the two's complement difference.

A flag stage watches the top slice. It reports signed overflow when the two values that reach the adder share a sign bit and the sum has the other sign. It raises an exception request only when the operation is marked signed, so unsigned arithmetic never traps. The result and all flags are captured in output registers, and a synchronous active-high reset clears them. A value driven on the inputs before a rising clock edge appears on the outputs after that edge.

Top module: `bitslice_alu`

## Requirements
- R1: With op_sel = 0, result_q equals a_in AND b_in, bit by bit.
- R2: With op_sel = 1, result_q equals a_in OR b_in.
- R3: With op_sel = 2, result_q equals NOT(a_in OR b_in).
- R4: With op_sel = 3 and sub_en = 0, result_q equals (a_in + b_in) mod 2^WIDTH, and carry_q equals bit WIDTH of the full sum.
- R5: With op_sel = 3 and sub_en = 1, result_q equals (a_in − b_in) mod 2^WIDTH, formed as a_in + ~b_in + 1. carry_q is 1 exactly when a_in ≥ b_in as unsigned numbers.
- R6: ovf_q is 1 exactly when op_sel = 3, the sign bit of a_in equals the sign bit of the operand fed to the adder (b_in, or ~b_in when subtracting), and the sign bit of the sum differs from them. For op_sel 0 to 2, ovf_q is 0.
- R7: exc_q equals ovf_q when signed_en = 1 and is always 0 when signed_en = 0. In unsigned mode ovf_q is still reported.
- R8: carry_q is 0 for op_sel 0, 1 and 2.
- R9: On a rising edge with rst = 1, result_q, carry_q, ovf_q and exc_q all become 0.
- R10: The outputs take values computed from the inputs sampled at the most recent rising edge. A change of the inputs between edges does not alter the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| op_sel | input | 2 | 0 AND, 1 OR, 2 NOR, 3 add/subtract |
| sub_en | input | 1 | 1 inverts b_in and sets the carry into slice 0 |
| signed_en | input | 1 | 1 lets overflow raise an exception |
| result_q | output | WIDTH | Registered result |
| carry_q | output | 1 | Registered carry out of the top slice (arithmetic only) |
| ovf_q | output | 1 | Registered signed overflow flag |
| exc_q | output | 1 | Registered exception request |

## Verification
The bench builds two copies of the unit. One uses the default WIDTH = 32; the other uses WIDTH = 4.

The 4-bit copy is small enough to sweep every operand pair under every op code, subtract setting and signedness. This covers all sign combinations and all carry chains that end in overflow. The 32-bit copy takes random operands together with the named corner sums: 0x7FFFFFFF+1, 0x80000000−1 and 0x80000000+0x80000000, each in signed and unsigned mode. It also gets directed checks of reset clearing and of the one-edge capture.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_NOR = 2'd2,
    OP_SUM = 2'd3
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    ai,
  input  logic    bi,
  input  logic    ci,
  input  logic    inv_b,
  input  alu_op_e op,
  output logic    b_used,
  output logic    sum,
  output logic    res,
  output logic    co
);
  logic bx;

  always_comb begin
    bx     = bi ^ inv_b;
    b_used = bx;
    sum    = ai ^ bx ^ ci;
    co     = (ai & bx) | (ai & ci) | (bx & ci);
    unique case (op)
      OP_AND:  res = ai & bi;
      OP_OR:   res = ai | bi;
      OP_NOR:  res = ~(ai | bi);
      default: res = sum;
    endcase
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  input  logic             sub,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             a_top,
  output logic             b_top,
  output logic             s_top
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sums;
  logic [WIDTH-1:0] b_fed;

  assign carry[0] = sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .ai    (a[i]),
      .bi    (b[i]),
      .ci    (carry[i]),
      .inv_b (sub),
      .op    (op),
      .b_used(b_fed[i]),
      .sum   (sums[i]),
      .res   (res[i]),
      .co    (carry[i+1])
    );
  end

  assign cout  = carry[WIDTH];
  assign a_top = a[MSB];
  assign b_top = b_fed[MSB];
  assign s_top = sums[MSB];
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  alu_op_e op,
  input  logic    signed_en,
  input  logic    cout,
  input  logic    a_top,
  input  logic    b_top,
  input  logic    s_top,
  output logic    carry,
  output logic    ovf,
  output logic    exc
);
  logic arith;
  logic ovf_raw;

  always_comb begin
    arith   = (op == OP_SUM);
    ovf_raw = (a_top == b_top) && (s_top != a_top);
    carry   = arith & cout;
    ovf     = arith & ovf_raw;
    exc     = ovf & signed_en;
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [1:0]       op_sel,
  input  logic             sub_en,
  input  logic             signed_en,
  output logic [WIDTH-1:0] result_q,
  output logic             carry_q,
  output logic             ovf_q,
  output logic             exc_q
);
  alu_op_e          op;
  logic [WIDTH-1:0] res_d;
  logic             cout, a_top, b_top, s_top;
  logic             carry_d, ovf_d, exc_d;

  assign op = alu_op_e'(op_sel);

  alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a    (a_in),
    .b    (b_in),
    .op   (op),
    .sub  (sub_en),
    .res  (res_d),
    .cout (cout),
    .a_top(a_top),
    .b_top(b_top),
    .s_top(s_top)
  );

  alu_flags u_flags (
    .op       (op),
    .signed_en(signed_en),
    .cout     (cout),
    .a_top    (a_top),
    .b_top    (b_top),
    .s_top    (s_top),
    .carry    (carry_d),
    .ovf      (ovf_d),
    .exc      (exc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      carry_q  <= 1'b0;
      ovf_q    <= 1'b0;
      exc_q    <= 1'b0;
    end else begin
      result_q <= res_d;
      carry_q  <= carry_d;
      ovf_q    <= ovf_d;
      exc_q    <= exc_d;
    end
  end

  // R7
  exc_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
    exc_q |-> $past(signed_en));

  // R6
  ovf_logic_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> ($past(op_sel) == 2'd3));

  // R8
  carry_logic_chk: assert property (@(posedge clk) disable iff (rst)
    carry_q |-> ($past(op_sel) == 2'd3));

  // R5
  sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_q && $past(op_sel) == 2'd3 && $past(sub_en)) |-> ($past(a_in) >= $past(b_in)));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result_q == '0 && !carry_q && !ovf_q && !exc_q));
endmodule

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;
  localparam int WW = 32;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [WW-1:0] wa = '0, wb = '0;
  logic [1:0]    wop = '0;
  logic          wsub = 1'b0, wsgn = 1'b0;
  logic [WW-1:0] wres;
  logic          wc, wv, we;

  logic [NW-1:0] na = '0, nb = '0;
  logic [1:0]    nop = '0;
  logic          nsub = 1'b0, nsgn = 1'b0;
  logic [NW-1:0] nres;
  logic          nc, nv, ne;

  int checks = 0;
  int errors = 0;

  bitslice_alu #(.WIDTH(WW)) uut (
    .clk(clk), .rst(rst), .a_in(wa), .b_in(wb), .op_sel(wop),
    .sub_en(wsub), .signed_en(wsgn),
    .result_q(wres), .carry_q(wc), .ovf_q(wv), .exc_q(we));

  bitslice_alu #(.WIDTH(NW)) uut_narrow (
    .clk(clk), .rst(rst), .a_in(na), .b_in(nb), .op_sel(nop),
    .sub_en(nsub), .signed_en(nsgn),
    .result_q(nres), .carry_q(nc), .ovf_q(nv), .exc_q(ne));

  // model returns {e, v, c, res[31:0]}
  function automatic logic [34:0] model(int w, logic [31:0] a, logic [31:0] b,
                                        logic [1:0] op, logic sub, logic sgn);
    logic [63:0] mask, aa, bb, s, r;
    logic c, v;
    mask = (64'd1 << w) - 64'd1;
    aa = {32'd0, a} & mask;
    bb = sub ? (~{32'd0, b} & mask) : ({32'd0, b} & mask);
    s  = aa + bb + {63'd0, sub};
    case (op)
      2'd0: r = aa & {32'd0, b};
      2'd1: r = aa | {32'd0, b};
      2'd2: r = ~(aa | {32'd0, b}) & mask;
      default: r = s & mask;
    endcase
    c = (op == 2'd3) ? s[w] : 1'b0;
    v = (op == 2'd3) && (aa[w-1] == bb[w-1]) && (s[w-1] != aa[w-1]);
    return {v & sgn, v, c, r[31:0]};
  endfunction

  function automatic string res_tag(logic [1:0] op, logic sub);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return sub ? "R5" : "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(int w, logic [31:0] a, logic [31:0] b, logic [1:0] op,
                         logic sub, logic sgn, logic [31:0] r, logic c, logic v, logic e);
    logic [34:0] m;
    m = model(w, a, b, op, sub, sgn);
    chk(res_tag(op, sub), r, m[31:0]);
    chk((op == 2'd3) ? (sub ? "R5 carry" : "R4 carry") : "R8", {31'd0, c}, {31'd0, m[32]});
    chk("R6", {31'd0, v}, {31'd0, m[33]});
    chk("R7", {31'd0, e}, {31'd0, m[34]});
  endtask

  // drive at negedge, check just after the capturing edge (R10)
  task automatic run_wide(logic [31:0] a, logic [31:0] b, logic [1:0] op, logic sub, logic sgn);
    @(negedge clk);
    wa = a; wb = b; wop = op; wsub = sub; wsgn = sgn;
    @(posedge clk); #1;
    compare(WW, a, b, op, sub, sgn, wres, wc, wv, we);
  endtask

  task automatic run_narrow(logic [3:0] a, logic [3:0] b, logic [1:0] op, logic sub, logic sgn);
    @(negedge clk);
    na = a; nb = b; nop = op; nsub = sub; nsgn = sgn;
    @(posedge clk); #1;
    compare(NW, {28'd0, a}, {28'd0, b}, op, sub, sgn, {28'd0, nres}, nc, nv, ne);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    wa = 32'h7FFFFFFF; wb = 32'h1; wop = 2'd3; wsgn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9", wres, 32'd0);
    chk("R9", {29'd0, wc, wv, we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // corner sums, signed and unsigned
    for (int s = 0; s < 2; s++) begin
      run_wide(32'h7FFFFFFF, 32'h1, 2'd3, 1'b0, s[0]);
      run_wide(32'h80000000, 32'h1, 2'd3, 1'b1, s[0]);
      run_wide(32'h80000000, 32'h80000000, 2'd3, 1'b0, s[0]);
      run_wide(32'h0, 32'h0, 2'd3, 1'b1, s[0]);
      run_wide(32'hFFFFFFFF, 32'h1, 2'd3, 1'b0, s[0]);
      run_wide(32'h5, 32'h7, 2'd3, 1'b1, s[0]);
    end
    run_wide(32'hF0F0_1234, 32'h0FF0_FFFF, 2'd0, 1'b1, 1'b1);
    run_wide(32'hF0F0_1234, 32'h0FF0_FFFF, 2'd1, 1'b1, 1'b1);
    run_wide(32'hF0F0_1234, 32'h0FF0_FFFF, 2'd2, 1'b0, 1'b1);

    // R10: inputs changed between edges leave outputs alone
    run_wide(32'h7FFFFFFF, 32'h1, 2'd3, 1'b0, 1'b1);
    @(negedge clk);
    wa = 32'h0; wb = 32'h0; wop = 2'd0; wsgn = 1'b0;
    #1;
    chk("R10", wres, 32'h80000000);
    chk("R10", {31'd0, we}, 32'd1);

    // R9 mid-run reset
    rst = 1'b1;
    wa = 32'hFFFFFFFF; wb = 32'hFFFFFFFF; wop = 2'd3;
    @(posedge clk); #1;
    chk("R9", wres, 32'd0);
    chk("R9", {29'd0, wc, wv, we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // random wide stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb, rk;
      ra = $urandom; rb = $urandom; rk = $urandom;
      if (rk[8]) ra[31] = rb[31];
      run_wide(ra, rb, rk[1:0], rk[2], rk[3]);
    end

    // exhaustive narrow sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int k = 0; k < 16; k++)
          run_narrow(a[3:0], b[3:0], k[1:0], k[2], k[3]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule